// File: doc/BRIEF.md
# Endpoint Token Handshake Responder

This block chooses the bus reply of a USB device bulk or interrupt endpoint to each token that the packet decoder presents. For every endpoint it keeps two status bits, stalled and primed. Software sets and clears these bits with one-cycle strobes. The data path reports transmit-buffer underflow and receive-buffer overflow through two flags, which are sampled together with the token.

Each token arrives as a one-cycle strobe carrying a token type, an endpoint number, a flag saying whether the current transfer descriptor still has packets to come, and the two buffer flags. One cycle later the block returns a registered response code. The code stays on the output until the next token is answered. The serializer and the buffer logic act on that code.

Top module: `ep_token_responder`

## Requirements
- R1: A SETUP token (type code 0) is answered with IGNORE (response code 0), whatever the endpoint status.
- R2: A token whose type code is 4 to 7, or whose endpoint number is at or above the endpoint count, is answered with IGNORE.
- R3: On a stalled endpoint, IN (1), OUT (2) and PING (3) tokens are answered with STALL (code 1), even when the endpoint is also primed.
- R4: On an endpoint that is neither stalled nor primed, IN, OUT and PING tokens are answered with NAK (code 2).
- R5: On a primed endpoint that is not stalled, an IN token is answered with TRANSMIT (code 5). If the underflow flag is high with the token, the answer is BITSTUFF_ERR (code 6) instead.
- R6: On a primed endpoint that is not stalled, a PING token is answered with ACK (code 3).
- R7: On a primed endpoint that is not stalled, an OUT token is answered as follows: NAK if the overflow flag is high; otherwise RX_ACK (code 7) if the more-packets flag is high; otherwise RX_NYET (code 4).
- R8: `resp_valid` pulses high exactly one cycle after `tok_valid`. `resp_code` changes only in that cycle and holds its value in between.
- R9: Bit i of a set strobe sets that status bit of endpoint i at the next edge, and bit i of a clear strobe clears it. When both strobes hit the same bit in the same cycle, the set wins. Stall strobes never change the primed bits, and prime strobes never change the stalled bits.
- R10: A token is judged against the status as it stood before any strobe in the same cycle takes effect.
- R11: After reset, all status bits are 0, `resp_code` is IGNORE and `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token strobe |
| tok_type | input | 3 | Token type: 0 SETUP, 1 IN, 2 OUT, 3 PING, 4-7 invalid |
| tok_ep | input | EPW | Endpoint number |
| more_pkts | input | 1 | Descriptor has packets remaining |
| tx_underflow | input | 1 | Transmit buffer underflow |
| rx_overflow | input | 1 | Receive buffer overflow |
| stall_set | input | NUM_EP | Per-endpoint stall set strobes |
| stall_clr | input | NUM_EP | Per-endpoint stall clear strobes |
| prime_set | input | NUM_EP | Per-endpoint prime set strobes |
| prime_clr | input | NUM_EP | Per-endpoint prime clear strobes |
| resp_valid | output | 1 | Response strobe, one cycle after the token |
| resp_code | output | 3 | Held response code |
| ep_stalled | output | NUM_EP | Stall status bits |
| ep_primed | output | NUM_EP | Primed status bits |

## Verification
The two functions that can coincide are answering a token and updating status from a software strobe, sometimes on the very endpoint the token names. The random phase drives token strobes and all four strobe vectors independently in most cycles, so these collisions occur often. Directed cases then pair a clear-stall with a token on the same endpoint, and a simultaneous set and clear on the same bit. The bench model computes each answer from the status before the strobes take effect (R10). It then checks the status outputs after the strobes, which covers set-wins and the independence of the two bits.

// File: rtl/ep_token_responder.sv
module ep_token_responder #(
  parameter int NUM_EP = 4,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [2:0]        tok_type,
  input  logic [EPW-1:0]    tok_ep,
  input  logic              more_pkts,
  input  logic              tx_underflow,
  input  logic              rx_overflow,
  input  logic [NUM_EP-1:0] stall_set,
  input  logic [NUM_EP-1:0] stall_clr,
  input  logic [NUM_EP-1:0] prime_set,
  input  logic [NUM_EP-1:0] prime_clr,
  output logic              resp_valid,
  output logic [2:0]        resp_code,
  output logic [NUM_EP-1:0] ep_stalled,
  output logic [NUM_EP-1:0] ep_primed
);

  localparam logic [2:0] T_SETUP = 3'd0, T_IN = 3'd1, T_OUT = 3'd2, T_PING = 3'd3;
  localparam logic [2:0] R_IGNORE = 3'd0, R_STALL = 3'd1, R_NAK = 3'd2, R_ACK = 3'd3,
                         R_RXNYET = 3'd4, R_XMIT = 3'd5, R_BSERR = 3'd6, R_RXACK = 3'd7;

  logic       ep_ok, stl, prm;
  logic [2:0] nxt_code;

  assign ep_ok = 32'(tok_ep) < NUM_EP;
  assign stl   = ep_ok && ep_stalled[tok_ep];
  assign prm   = ep_ok && ep_primed[tok_ep];

  always_comb begin
    nxt_code = R_IGNORE;
    if (ep_ok && (tok_type == T_IN || tok_type == T_OUT || tok_type == T_PING)) begin
      if (stl)
        nxt_code = R_STALL;
      else if (!prm)
        nxt_code = R_NAK;
      else if (tok_type == T_IN)
        nxt_code = tx_underflow ? R_BSERR : R_XMIT;
      else if (tok_type == T_PING)
        nxt_code = R_ACK;
      else if (rx_overflow)
        nxt_code = R_NAK;
      else
        nxt_code = more_pkts ? R_RXACK : R_RXNYET;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_stalled <= '0;
      ep_primed  <= '0;
      resp_valid <= 1'b0;
      resp_code  <= R_IGNORE;
    end else begin
      ep_stalled <= (ep_stalled & ~stall_clr) | stall_set;
      ep_primed  <= (ep_primed & ~prime_clr) | prime_set;
      resp_valid <= tok_valid;
      if (tok_valid) resp_code <= nxt_code;
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> resp_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> ($stable(resp_code) && !resp_valid));
  p_setup_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_type == T_SETUP) |=> resp_code == R_IGNORE);
  p_invalid_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_type[2]) |=> resp_code == R_IGNORE);
  p_stall_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && stl && tok_type != T_SETUP && !tok_type[2]) |=> resp_code == R_STALL);
  p_prime_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prime_set == '0 && prime_clr == '0) |=> $stable(ep_primed));
  p_stall_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_set == '0 && stall_clr == '0) |=> $stable(ep_stalled));

endmodule

// File: tb/tb_ep_token_responder.sv
module tb_ep_token_responder;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 4;
  localparam int EPW = 2;

  logic clk = 0, rst_n = 0;
  logic tok_valid = 0, more_pkts = 0, tx_underflow = 0, rx_overflow = 0;
  logic [2:0] tok_type = 0;
  logic [EPW-1:0] tok_ep = 0;
  logic [NUM_EP-1:0] stall_set = 0, stall_clr = 0, prime_set = 0, prime_clr = 0;
  logic resp_valid;
  logic [2:0] resp_code;
  logic [NUM_EP-1:0] ep_stalled, ep_primed;

  ep_token_responder #(.NUM_EP(NUM_EP)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [NUM_EP-1:0] m_stl = 0, m_prm = 0;
  logic [2:0] m_code = 0;

  function automatic logic [2:0] expect_code(logic [2:0] t, logic s, logic p,
      logic mp, logic uf, logic ov);
    if (t == 0 || t > 3) return 3'd0;
    if (s) return 3'd1;
    if (!p) return 3'd2;
    if (t == 1) return uf ? 3'd6 : 3'd5;
    if (t == 3) return 3'd3;
    if (ov) return 3'd2;
    return mp ? 3'd7 : 3'd4;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
      finish_up();
    end
  end

  // drive one cycle: inputs set at negedge, outputs checked at the following negedge
  task automatic step(logic tv, logic [2:0] tt, logic [EPW-1:0] te, logic mp, logic uf,
      logic ov, logic [NUM_EP-1:0] ss, logic [NUM_EP-1:0] sc,
      logic [NUM_EP-1:0] ps, logic [NUM_EP-1:0] pc, string tag);
    tok_valid = tv; tok_type = tt; tok_ep = te; more_pkts = mp;
    tx_underflow = uf; rx_overflow = ov;
    stall_set = ss; stall_clr = sc; prime_set = ps; prime_clr = pc;
    if (tv) m_code = expect_code(tt, m_stl[te], m_prm[te], mp, uf, ov);  // R10: old status
    m_stl = (m_stl & ~sc) | ss;
    m_prm = (m_prm & ~pc) | ps;
    @(negedge clk);
    chk({tag, " R8 valid"}, resp_valid, tv);
    chk({tag, " code"}, resp_code, m_code);
    chk({tag, " R9 stall"}, ep_stalled, m_stl);
    chk({tag, " R9 prime"}, ep_primed, m_prm);
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk); @(negedge clk);
    chk("R11 valid", resp_valid, 0);
    chk("R11 code", resp_code, 0);
    chk("R11 status", {ep_stalled, ep_primed}, 0);
    rst_n = 1;

    // R4 unprimed NAK; R1 SETUP ignored
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 in");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 setup");
    // R10: prime in same cycle as token -> still NAK
    step(1, 3, 1, 0, 0, 0, 0, 0, 4'b0010, 0, "R10 ping");
    step(1, 3, 1, 0, 0, 0, 0, 0, 0, 0, "R6 ping");
    step(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R5 xmit");
    step(1, 1, 1, 0, 1, 0, 0, 0, 0, 0, "R5 underflow");
    step(1, 2, 1, 1, 0, 0, 0, 0, 0, 0, "R7 ack");
    step(1, 2, 1, 0, 0, 0, 0, 0, 0, 0, "R7 nyet");
    step(1, 2, 1, 1, 0, 1, 0, 0, 0, 0, "R7 overflow");
    step(0, 2, 1, 0, 0, 0, 0, 0, 0, 0, "R8 hold");
    step(1, 5, 1, 0, 0, 0, 0, 0, 0, 0, "R2 invalid");
    // R3 stall beats primed; clear-stall keeps primed (R9)
    step(0, 0, 0, 0, 0, 0, 4'b0010, 0, 0, 0, "R9 setstall");
    step(1, 1, 1, 0, 0, 0, 0, 4'b0010, 0, 0, "R3 stalled primed");
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R1 setup after clr");
    step(1, 1, 1, 0, 0, 0, 4'b0100, 4'b0100, 4'b0100, 4'b0100, "R9 set wins");
    step(1, 2, 2, 0, 0, 0, 0, 0, 0, 0, "R3 ep2");

    for (int i = 0; i < 3000; i++) begin
      logic [NUM_EP-1:0] ss, sc, ps, pc;
      ss = ($urandom % 4 == 0) ? NUM_EP'($urandom) : '0;
      sc = ($urandom % 3 == 0) ? NUM_EP'($urandom) : '0;
      ps = ($urandom % 3 == 0) ? NUM_EP'($urandom) : '0;
      pc = ($urandom % 4 == 0) ? NUM_EP'($urandom) : '0;
      step(($urandom % 4) != 0, 3'(($urandom % 5 == 0) ? $urandom : $urandom % 4),
           EPW'($urandom), 1'($urandom), 1'($urandom % 3 == 0), 1'($urandom % 3 == 0),
           ss, sc, ps, pc, "R1-7 random");
    end
    finish_up();
  end
endmodule